// File: doc/BRIEF.md
# Thread-Context Special-Operation Decoder

This block sits on the access path to the per-thread interrupt context area. Each request carries an offset, a size in bytes, a read/write flag, one byte of write data, and a flag that picks the OS page or the hypervisor page. Offsets with bit 11 set belong to the special region. There, the page, the offset, the exact size and the direction together pick one operation that has a side effect. The operations are:

- acknowledge on the OS ring;
- set-pending on the OS ring;
- acknowledge on the hypervisor ring;
- pull of the OS context;
- pull of the pool context.

A special access that matches none of them is rejected. Offsets below the special region are left to the plain register path: this block only marks them as not claimed.

The block holds two context words. One is OS word 2 and the other is the pool word, and the most significant bit of each is its valid bit. A pull returns the word with the valid bit cleared, and it writes the same cleared word back at the clock edge that accepts the read. The dispatch logic installs context through the load inputs, and a load wins over a pull in the same cycle.

Requests use a valid/ready handshake. The response is a single output register, and `req_ready` is high whenever that register is empty or is being drained in the same cycle. A response that is not taken stays stable until `rsp_ready` is seen. Side-effect strobes pulse for exactly one cycle, in the first cycle that the response is valid.

Top module: `tm_special_ops`

## Requirements
- R1: After reset, `rsp_valid` is 0, both context words are 0, `req_ready` is 1 and every strobe is 0.
- R2: A request whose offset has bit 11 clear gives a response with `rsp_claim`=0, `rsp_err`=0 and `rsp_rdata`=0. It pulses no strobe and changes no context word.
- R3: A request with offset bit 11 set that matches no operation gives `rsp_claim`=1, `rsp_err`=1 and `rsp_rdata`=0. It also raises `err_pulse` for one cycle, pulses no other strobe and leaves both context words unchanged.
- R4: An OS-page (`req_hv`=0) read of size 2 at offset 0xC10 pulses `ack_os` and returns read data 0.
- R5: An OS-page write of size 1 at offset 0xC20 pulses `os_notify`, with `notify_prio` equal to the write byte, and returns read data 0.
- R6: A hypervisor-page (`req_hv`=1) read of size 4 or 8 at offset 0x818 clears bit 31 of OS word 2. It returns that cleared 32-bit word, zero-extended to 64 bits, and pulses `os_upd`.
- R7: A hypervisor-page read of size 2 at offset 0x830 pulses `ack_hv` and returns read data 0.
- R8: A hypervisor-page read of size 4 or 8 at offset 0x828 clears bit 31 of the pool word. It returns that cleared word, zero-extended, and pulses `pool_upd`.
- R9: The response is valid in the cycle after acceptance. The strobes pulse in that same cycle only, and at most one strobe is high in any cycle.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay stable and no request is accepted.
- R11: A load updates its context word at the next edge. A load in the same cycle as a pull wins the word, while the pull still returns the pre-load word with bit 31 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_hv | input | 1 | 1 = hypervisor page, 0 = OS page |
| req_offset | input | 12 | Byte offset in the context area |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Rejected special access |
| rsp_claim | output | 1 | Access was in the special region |
| err_pulse | output | 1 | One-cycle error strobe |
| ack_os | output | 1 | OS acknowledge strobe |
| os_notify | output | 1 | OS ring re-evaluation strobe |
| notify_prio | output | 8 | Byte written by set-pending |
| ack_hv | output | 1 | Hypervisor acknowledge strobe |
| os_upd | output | 1 | OS word 2 pulled |
| pool_upd | output | 1 | Pool word pulled |
| os_load_en | input | 1 | Load OS word 2 |
| os_load_val | input | 32 | Value for OS word 2 |
| pool_load_en | input | 1 | Load pool word |
| pool_load_val | input | 32 | Value for pool word |
| os_w2 | output | 32 | Current OS word 2 |
| pool_w2 | output | 32 | Current pool word |

## Verification
Every result of an accepted request is due exactly one clock after the accepting edge. That covers read data, error, claim, the strobes and the pulled-back context words. The bench drives on the falling edge, lets one rising edge accept the request, and samples at the next falling edge. It then checks one falling edge later that the response has drained and every strobe has dropped. Under back-pressure it samples on several falling edges while `rsp_ready` is low, then checks that the waiting request is accepted on the edge where `rsp_ready` rises. The pull-versus-load case is sampled in the same way, one cycle after the edge where both arrive.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN,
    OP_BAD,
    OP_ACK_OS,
    OP_SET_PEND,
    OP_PULL_OS,
    OP_ACK_HV,
    OP_PULL_POOL
  } tm_op_e;
endpackage

// File: rtl/tm_op_decode.sv
module tm_op_decode
  import tm_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int SPC_BIT = 11,
  parameter logic [OFF_W-1:0] ACK_OS_OFF = 12'hC10,
  parameter logic [OFF_W-1:0] SET_PEND_OFF = 12'hC20,
  parameter logic [OFF_W-1:0] PULL_OS_OFF = 12'h818,
  parameter logic [OFF_W-1:0] PULL_POOL_OFF = 12'h828,
  parameter logic [OFF_W-1:0] ACK_HV_OFF = 12'h830
) (
  input  logic             page_hv,
  input  logic [OFF_W-1:0] offset,
  input  logic [3:0]       size,
  input  logic             write,
  output tm_op_e           op
);
  typedef struct packed {
    logic             hv;
    logic [OFF_W-1:0] off;
    logic [3:0]       sz;
    logic             wr;
    tm_op_e           code;
  } entry_t;

  localparam int N_ENT = 7;
  localparam entry_t TBL [N_ENT] = '{
    '{hv: 1'b0, off: ACK_OS_OFF,    sz: 4'd2, wr: 1'b0, code: OP_ACK_OS},
    '{hv: 1'b0, off: SET_PEND_OFF,  sz: 4'd1, wr: 1'b1, code: OP_SET_PEND},
    '{hv: 1'b1, off: PULL_OS_OFF,   sz: 4'd4, wr: 1'b0, code: OP_PULL_OS},
    '{hv: 1'b1, off: PULL_OS_OFF,   sz: 4'd8, wr: 1'b0, code: OP_PULL_OS},
    '{hv: 1'b1, off: ACK_HV_OFF,    sz: 4'd2, wr: 1'b0, code: OP_ACK_HV},
    '{hv: 1'b1, off: PULL_POOL_OFF, sz: 4'd4, wr: 1'b0, code: OP_PULL_POOL},
    '{hv: 1'b1, off: PULL_POOL_OFF, sz: 4'd8, wr: 1'b0, code: OP_PULL_POOL}
  };

  always_comb begin
    op = OP_PLAIN;
    if (offset[SPC_BIT]) begin
      op = OP_BAD;
      for (int i = 0; i < N_ENT; i++) begin
        if (TBL[i].hv == page_hv && TBL[i].off == offset &&
            TBL[i].sz == size && TBL[i].wr == write)
          op = TBL[i].code;
      end
    end
  end
endmodule

// File: rtl/tm_ctx_word.sv
module tm_ctx_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         pull,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)       word <= '0;
    else if (load_en) word <= load_val;
    else if (pull)    word <= {1'b0, word[W-2:0]};
  end

  // R6 / R8: a pull with no load leaves the valid bit clear
  a_r6_pull_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pull && !load_en |=> !word[W-1]);

  // R3: with neither load nor pull the word holds
  a_r3_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pull && !load_en |=> $stable(word));

  // R11: load wins
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> word == $past(load_val));
endmodule

// File: rtl/tm_special_ops.sv
module tm_special_ops
  import tm_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int SPC_BIT = 11,
  parameter int CTX_W = 32,
  parameter int RD_W = 64,
  parameter logic [OFF_W-1:0] ACK_OS_OFF = 12'hC10,
  parameter logic [OFF_W-1:0] SET_PEND_OFF = 12'hC20,
  parameter logic [OFF_W-1:0] PULL_OS_OFF = 12'h818,
  parameter logic [OFF_W-1:0] PULL_POOL_OFF = 12'h828,
  parameter logic [OFF_W-1:0] ACK_HV_OFF = 12'h830
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_hv,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [3:0]       req_size,
  input  logic             req_write,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [RD_W-1:0]  rsp_rdata,
  output logic             rsp_err,
  output logic             rsp_claim,
  output logic             err_pulse,
  output logic             ack_os,
  output logic             os_notify,
  output logic [7:0]       notify_prio,
  output logic             ack_hv,
  output logic             os_upd,
  output logic             pool_upd,
  input  logic             os_load_en,
  input  logic [CTX_W-1:0] os_load_val,
  input  logic             pool_load_en,
  input  logic [CTX_W-1:0] pool_load_val,
  output logic [CTX_W-1:0] os_w2,
  output logic [CTX_W-1:0] pool_w2
);
  localparam int PAD_W = RD_W - CTX_W;

  tm_op_e          op;
  logic            accept;
  logic            pull_os, pull_pool;
  logic [RD_W-1:0] rd_next;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign pull_os   = accept && (op == OP_PULL_OS);
  assign pull_pool = accept && (op == OP_PULL_POOL);

  tm_op_decode #(
    .OFF_W(OFF_W), .SPC_BIT(SPC_BIT),
    .ACK_OS_OFF(ACK_OS_OFF), .SET_PEND_OFF(SET_PEND_OFF),
    .PULL_OS_OFF(PULL_OS_OFF), .PULL_POOL_OFF(PULL_POOL_OFF),
    .ACK_HV_OFF(ACK_HV_OFF)
  ) u_dec (
    .page_hv(req_hv), .offset(req_offset), .size(req_size),
    .write(req_write), .op(op)
  );

  tm_ctx_word #(.W(CTX_W)) u_os_word (
    .clk(clk), .rst_n(rst_n), .load_en(os_load_en), .load_val(os_load_val),
    .pull(pull_os), .word(os_w2)
  );

  tm_ctx_word #(.W(CTX_W)) u_pool_word (
    .clk(clk), .rst_n(rst_n), .load_en(pool_load_en), .load_val(pool_load_val),
    .pull(pull_pool), .word(pool_w2)
  );

  always_comb begin
    case (op)
      OP_PULL_OS:   rd_next = {{PAD_W{1'b0}}, 1'b0, os_w2[CTX_W-2:0]};
      OP_PULL_POOL: rd_next = {{PAD_W{1'b0}}, 1'b0, pool_w2[CTX_W-2:0]};
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      rsp_claim   <= 1'b0;
      err_pulse   <= 1'b0;
      ack_os      <= 1'b0;
      os_notify   <= 1'b0;
      ack_hv      <= 1'b0;
      os_upd      <= 1'b0;
      pool_upd    <= 1'b0;
      notify_prio <= '0;
    end else begin
      err_pulse <= accept && (op == OP_BAD);
      ack_os    <= accept && (op == OP_ACK_OS);
      os_notify <= accept && (op == OP_SET_PEND);
      ack_hv    <= accept && (op == OP_ACK_HV);
      os_upd    <= pull_os;
      pool_upd  <= pull_pool;
      if (accept && op == OP_SET_PEND) notify_prio <= req_wdata;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_next;
        rsp_err   <= (op == OP_BAD);
        rsp_claim <= (op != OP_PLAIN);
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R9: strobes are mutually exclusive
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_pulse, ack_os, os_notify, ack_hv, os_upd, pool_upd}));

  // R9: every strobe coincides with a valid response
  a_r9_strobe_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse || ack_os || os_notify || ack_hv || os_upd || pool_upd) |-> rsp_valid);

  // R10: a stalled response is held
  a_r10_hold_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) &&
                                $stable(rsp_err) && $stable(rsp_claim));

  // R3: rejected accesses return zero and pulse the error strobe
  a_r3_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> rsp_err && rsp_claim && rsp_rdata == '0);

  // R2: unclaimed accesses are never errors
  a_r2_plain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_claim |-> !rsp_err && rsp_rdata == '0);

  // R6: a pulled OS word is returned with its valid bit clear
  a_r6_pull_data: assert property (@(posedge clk) disable iff (!rst_n)
    os_upd |-> !rsp_rdata[CTX_W-1] && rsp_rdata[RD_W-1:CTX_W] == '0);
endmodule

// File: tb/tm_special_ops_bench.sv
module tm_special_ops_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_hv, req_write;
  logic [11:0] req_offset;
  logic [3:0]  req_size;
  logic [7:0]  req_wdata, notify_prio;
  logic        rsp_valid, rsp_ready, rsp_err, rsp_claim;
  logic [63:0] rsp_rdata;
  logic        err_pulse, ack_os, os_notify, ack_hv, os_upd, pool_upd;
  logic        os_load_en, pool_load_en;
  logic [31:0] os_load_val, pool_load_val, os_w2, pool_w2;

  tm_special_ops u_tm_special_ops (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hv(req_hv), .req_offset(req_offset), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_claim(rsp_claim), .err_pulse(err_pulse), .ack_os(ack_os),
    .os_notify(os_notify), .notify_prio(notify_prio), .ack_hv(ack_hv),
    .os_upd(os_upd), .pool_upd(pool_upd), .os_load_en(os_load_en),
    .os_load_val(os_load_val), .pool_load_en(pool_load_en),
    .pool_load_val(pool_load_val), .os_w2(os_w2), .pool_w2(pool_w2)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] strobes();
    return {err_pulse, ack_os, os_notify, ack_hv, os_upd, pool_upd};
  endfunction

  // 0 plain, 1 bad, 2 ack os, 3 set pend, 4 pull os, 5 ack hv, 6 pull pool
  function automatic int model(input bit hv, input int off, input int sz, input bit wr);
    if (off < 'h800) return 0;
    if (!hv && off == 'hC10 && sz == 2 && !wr) return 2;
    if (!hv && off == 'hC20 && sz == 1 && wr) return 3;
    if (hv && off == 'h818 && (sz == 4 || sz == 8) && !wr) return 4;
    if (hv && off == 'h830 && sz == 2 && !wr) return 5;
    if (hv && off == 'h828 && (sz == 4 || sz == 8) && !wr) return 6;
    return 1;
  endfunction

  function automatic string tag_of(input int e);
    case (e)
      0: return "R2 plain";
      1: return "R3 reject";
      2: return "R4 ack_os";
      3: return "R5 set_pend";
      4: return "R6 pull_os";
      5: return "R7 ack_hv";
      default: return "R8 pull_pool";
    endcase
  endfunction

  task automatic load_words(input logic [31:0] o, input logic [31:0] p);
    @(negedge clk);
    os_load_en = 1; os_load_val = o; pool_load_en = 1; pool_load_val = p;
    @(negedge clk);
    os_load_en = 0; pool_load_en = 0;
  endtask

  task automatic txn(input bit hv, input int off, input int sz, input bit wr,
                     input logic [7:0] wd, input logic [31:0] o, input logic [31:0] p);
    int e;
    string t;
    logic [5:0] exp_stb;
    load_words(o, p);
    req_valid = 1; req_hv = hv; req_offset = 12'(off); req_size = 4'(sz);
    req_write = wr; req_wdata = wd; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    e = model(hv, off, sz, wr);
    t = tag_of(e);
    exp_stb = {e == 1, e == 2, e == 3, e == 5, e == 4, e == 6};
    chk({t, " R9 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({t, " claim"}, 64'(rsp_claim), 64'(e != 0));
    chk({t, " err"}, 64'(rsp_err), 64'(e == 1));
    chk({t, " rdata"}, rsp_rdata,
        e == 4 ? {33'd0, o[30:0]} : e == 6 ? {33'd0, p[30:0]} : 64'd0);
    chk({t, " R9 strobes"}, 64'(strobes()), 64'(exp_stb));
    chk({t, " os_w2"}, 64'(os_w2), 64'(e == 4 ? {1'b0, o[30:0]} : o));
    chk({t, " pool_w2"}, 64'(pool_w2), 64'(e == 6 ? {1'b0, p[30:0]} : p));
    if (e == 3) chk("R5 notify_prio", 64'(notify_prio), 64'(wd));
    @(negedge clk);
    chk("R9 rsp drained", 64'(rsp_valid), 64'd0);
    chk("R9 strobes one cycle", 64'(strobes()), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_hv = 0; req_offset = '0; req_size = '0;
    req_write = 0; req_wdata = '0; rsp_ready = 1;
    os_load_en = 0; pool_load_en = 0; os_load_val = '0; pool_load_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 os_w2", 64'(os_w2), 64'd0);
    chk("R1 pool_w2", 64'(pool_w2), 64'd0);
    chk("R1 strobes", 64'(strobes()), 64'd0);

    // Sweep of page, offset (step 8), size and direction
    for (int hv = 0; hv < 2; hv++)
      for (int off = 0; off < 4096; off += 8)
        for (int si = 0; si < 4; si++)
          for (int wr = 0; wr < 2; wr++)
            txn(hv[0], off, 1 << si, wr[0], 8'(off ^ (si * 37)),
                32'h8000_0000 | 32'(off * 32'h9E37 + si),
                32'hC000_0000 ^ 32'(off * 7 + wr));

    // R10: back-pressure
    load_words(32'h8000_00A5, 32'h8000_005A);
    req_valid = 1; req_hv = 1; req_offset = 12'h818; req_size = 4'd4;
    req_write = 0; rsp_ready = 0;
    @(negedge clk);
    req_hv = 0; req_offset = 12'hC10; req_size = 4'd2;
    chk("R10 stalled rsp valid", 64'(rsp_valid), 64'd1);
    chk("R10 stalled data", rsp_rdata, 64'h0000_00A5);
    chk("R10 req_ready low", 64'(req_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held valid", 64'(rsp_valid), 64'd1);
      chk("R10 held data", rsp_rdata, 64'h0000_00A5);
      chk("R10 no accept while stalled", 64'(ack_os), 64'd0);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 next accepted on drain", 64'(ack_os), 64'd1);
    chk("R10 next rsp claim", 64'(rsp_claim), 64'd1);
    chk("R4 ack data", rsp_rdata, 64'd0);
    @(negedge clk);

    // R11: load and pull in the same cycle
    load_words(32'h8000_1234, 32'h8000_0001);
    os_load_en = 1; os_load_val = 32'h8765_4321;
    req_valid = 1; req_hv = 1; req_offset = 12'h818; req_size = 4'd8; req_write = 0;
    @(negedge clk);
    os_load_en = 0; req_valid = 0;
    chk("R11 pull returns pre-load word", rsp_rdata, 64'h0000_1234);
    chk("R11 load wins word", 64'(os_w2), 64'h8765_4321);
    chk("R11 os_upd", 64'(os_upd), 64'd1);
    @(negedge clk);

    finish_run();
  end
endmodule